// File: doc/BRIEF.md
# Spread-Spectrum Modulation Profile Generator

This block generates the digital steering code for a spread-spectrum clock synthesizer. The code is a signed frequency offset in units of 0.01 % of the nominal frequency, and it traces a linear triangle that repeats every `PERIOD_CYC` system clocks. The default is 4000 clocks, which is 80 µs at 50 MHz and so a 12.5 kHz modulation rate. A current-output DAC after this block turns the code into the small periodic frequency change that spreads the clock spectrum and lowers its emission peaks.

Two spread styles are supported. Center spread swings the offset evenly above and below zero. Down spread keeps the offset at or below zero, so the synthesized clock never runs faster than its input. A depth select picks the shallow or the deep swing for either style. Modulation can be switched off, and the block can be put into power-down; in both cases the code sits at exactly zero. When modulation resumes, the profile restarts from the middle of its range. A change to the style or depth selects waits until the ramp reaches its own midpoint, so the code never jumps partway along a ramp.

The offset is produced with an error-accumulating ramp. The ramp lands exactly on each turning point and does not drift from one period to the next.

Top module: `ssc_profile_gen`

## Requirements
- R1: While `rst_n` is low, `offset_o` is 0 and `active_o` is 0.
- R2: With `spread_down_i`=0, the offset swings symmetrically between +A and −A. A is `AMP_LO` (default 50, meaning 0.5 %) when `depth_hi_i`=0 and `AMP_HI` (default 150, meaning 1.5 %) when `depth_hi_i`=1. One LSB is 0.01 %.
- R3: With `spread_down_i`=1, the offset swings between 0 and −2A, which is −100 or −300 by default, and is never positive.
- R4: Let t be the number of clocks since the profile started, taken modulo `PERIOD_CYC`. Let Q = `PERIOD_CYC`/4, r = t mod Q and f = floor(A·r/Q). The ramp value is f in quarter 0, A−f in quarter 1, −f in quarter 2 and −A+f in quarter 3. `offset_o` is this ramp value plus the midpoint, which is 0 for center spread and −A for down spread.
- R5: In the clock after `mod_en_i` is sampled low, `offset_o` is 0 and `active_o` is 0, and they stay so while `mod_en_i` stays low.
- R6: In the clock after `pd_n` is sampled low, `offset_o` is 0 and `active_o` is 0, and they stay so while `pd_n` stays low.
- R7: On the first active clock after power-down or disable ends, t is 0 and `offset_o` equals the midpoint of the selected style and depth.
- R8: `spread_down_i` and `depth_hi_i` are taken when the profile starts and at the clock edges that bring t to 0 or to 2Q, where the ramp value is zero. At any other time a change has no effect on `offset_o`.
- R9: `active_o` goes high in the clock after `pd_n` and `mod_en_i` are both sampled high, and it stays high while they stay high.
- R10: While the style and depth in force do not change, `offset_o` changes by at most one LSB per clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; one profile tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Active-low power-down |
| mod_en_i | input | 1 | Modulation enable |
| spread_down_i | input | 1 | 1 = down spread, 0 = center spread |
| depth_hi_i | input | 1 | 1 = deep swing (`AMP_HI`), 0 = shallow swing (`AMP_LO`) |
| offset_o | output | OFF_W | Signed offset code, 0.01 % per LSB |
| active_o | output | 1 | High while the profile is being produced |

## Verification
The bench aims at the turning points. A ramp that rounded its step would fall short of ±150 or −300, or would drift a little further off in each period. It also changes the style and depth selects in the middle of a ramp. A design that applied them at once would let a deep value appear before the midpoint is reached, and it would jump by more than one LSB in a single clock. It also pulses enable and power-down. A design that went on running during the pause, or that resumed at the phase where it stopped, would fail the zero-output check or the midpoint-restart check.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

   // Quarter of the triangle; the order is the ramp sequence
   typedef enum logic [1:0] {
      QTR_RISE_A = 2'd0,
      QTR_FALL_A = 2'd1,
      QTR_FALL_B = 2'd2,
      QTR_RISE_B = 2'd3
   } qtr_e;

   typedef struct packed {
      logic down;
      logic deep;
   } ssc_cfg_t;

   function automatic logic qtr_rising(qtr_e q);
      return (q == QTR_RISE_A) || (q == QTR_RISE_B);
   endfunction

endpackage

// File: rtl/ssc_phase.sv
module ssc_phase
   import ssc_pkg::*;
#(
   parameter int QTR_CYC = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active_i,
   output qtr_e qtr_o,
   output logic apply_o
);

   localparam int RW = (QTR_CYC > 1) ? $clog2(QTR_CYC) : 1;

   logic [RW-1:0] tick_q;
   qtr_e          qtr_q;
   logic          last_tick;

   assign last_tick = active_i && (tick_q == RW'(QTR_CYC - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tick_q <= '0;
         qtr_q  <= QTR_RISE_A;
      end else if (!active_i) begin
         tick_q <= '0;
         qtr_q  <= QTR_RISE_A;
      end else if (last_tick) begin
         tick_q <= '0;
         qtr_q  <= qtr_e'(qtr_q + 2'd1);
      end else begin
         tick_q <= tick_q + 1'b1;
      end
   end

   // The ramp value is zero where quarter 1 ends and where quarter 3 ends
   assign apply_o = last_tick && ((qtr_q == QTR_FALL_A) || (qtr_q == QTR_RISE_B));
   assign qtr_o   = qtr_q;

   // R4
   qtr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active_i && !last_tick) |=> (qtr_q == $past(qtr_q)));

endmodule

// File: rtl/ssc_ramp.sv
module ssc_ramp #(
   parameter int QTR_CYC = 1000,
   parameter int AMP_W   = 8,
   parameter int OFF_W   = 10
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    active_i,
   input  logic                    rising_i,
   input  logic [AMP_W-1:0]        amp_i,
   output logic signed [OFF_W-1:0] lvl_o
);

   localparam int EW = $clog2(2 * QTR_CYC) + 1;
   localparam logic signed [OFF_W-1:0] ONE = 1;

   logic [EW-1:0]           acc_q;
   logic [EW-1:0]           acc_sum;
   logic                    carry;
   logic signed [OFF_W-1:0] lvl_q;

   assign acc_sum = acc_q + EW'(amp_i);
   assign carry   = (acc_sum >= EW'(QTR_CYC));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         lvl_q <= '0;
      end else if (!active_i) begin
         acc_q <= '0;
         lvl_q <= '0;
      end else begin
         acc_q <= carry ? (acc_sum - EW'(QTR_CYC)) : acc_sum;
         if (carry) lvl_q <= rising_i ? (lvl_q + ONE) : (lvl_q - ONE);
      end
   end

   assign lvl_o = lvl_q;

   // R4
   acc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_q < EW'(QTR_CYC));

   // R10
   step_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      active_i |=> ((lvl_q == $past(lvl_q)) || (lvl_q == $past(lvl_q) + ONE) ||
                    (lvl_q == $past(lvl_q) - ONE)));

endmodule

// File: rtl/ssc_cfg.sv
module ssc_cfg
   import ssc_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     active_i,
   input  logic     apply_i,
   input  logic     down_i,
   input  logic     deep_i,
   output ssc_cfg_t cfg_o
);

   ssc_cfg_t cfg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cfg_q <= '0;
      else if (!active_i || apply_i)  cfg_q <= '{down: down_i, deep: deep_i};
   end

   assign cfg_o = cfg_q;

   // R8
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active_i && !apply_i) |=> (cfg_q == $past(cfg_q)));

endmodule

// File: rtl/ssc_profile_gen.sv
module ssc_profile_gen
   import ssc_pkg::*;
#(
   parameter int PERIOD_CYC = 4000,
   parameter int AMP_LO     = 50,
   parameter int AMP_HI     = 150,
   parameter int OFF_W      = 10
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    pd_n,
   input  logic                    mod_en_i,
   input  logic                    spread_down_i,
   input  logic                    depth_hi_i,
   output logic signed [OFF_W-1:0] offset_o,
   output logic                    active_o
);

   localparam int QTR_CYC = PERIOD_CYC / 4;
   localparam int AMP_W   = $clog2(AMP_HI + 1);

   // Elaboration-time parameter checks
   if (PERIOD_CYC % 4 != 0 || PERIOD_CYC < 8) begin : g_bad_period
      $error("PERIOD_CYC must be a multiple of 4 and at least 8");
   end
   if (AMP_LO < 1 || AMP_LO > AMP_HI) begin : g_bad_amp_order
      $error("AMP_LO must lie in 1..AMP_HI");
   end
   if (AMP_HI > QTR_CYC) begin : g_bad_amp_slope
      $error("AMP_HI must not exceed PERIOD_CYC/4 (one LSB per tick at most)");
   end
   if (2 * AMP_HI >= (1 << (OFF_W - 1))) begin : g_bad_width
      $error("OFF_W too narrow for a swing of 2*AMP_HI");
   end

   logic                    run;
   logic                    active_q;
   qtr_e                    qtr;
   logic                    apply;
   ssc_cfg_t                cfg;
   logic [AMP_W-1:0]        amp;
   logic signed [OFF_W-1:0] amp_s;
   logic signed [OFF_W-1:0] mid;
   logic signed [OFF_W-1:0] lvl;

   assign run = pd_n && mod_en_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) active_q <= 1'b0;
      else        active_q <= run;
   end

   ssc_phase #(.QTR_CYC(QTR_CYC)) u_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .active_i (active_q),
      .qtr_o    (qtr),
      .apply_o  (apply)
   );

   ssc_cfg u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .active_i (active_q),
      .apply_i  (apply),
      .down_i   (spread_down_i),
      .deep_i   (depth_hi_i),
      .cfg_o    (cfg)
   );

   assign amp   = cfg.deep ? AMP_W'(AMP_HI) : AMP_W'(AMP_LO);
   assign amp_s = $signed({{(OFF_W - AMP_W){1'b0}}, amp});
   assign mid   = cfg.down ? -amp_s : '0;

   ssc_ramp #(.QTR_CYC(QTR_CYC), .AMP_W(AMP_W), .OFF_W(OFF_W)) u_ramp (
      .clk      (clk),
      .rst_n    (rst_n),
      .active_i (active_q),
      .rising_i (qtr_rising(qtr)),
      .amp_i    (amp),
      .lvl_o    (lvl)
   );

   assign offset_o = active_q ? (mid + lvl) : '0;
   assign active_o = active_q;

   // R2
   amp_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      active_q |-> ((lvl <= amp_s) && (lvl >= -amp_s)));

   // R3
   down_nonpos_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && cfg.down) |-> (offset_o <= 0));

   // R5 R6
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> ((offset_o == 0) && !active_o));

   // R7
   restart_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active_q) |-> (lvl == 0));

endmodule

// File: tb/ssc_profile_gen_bench.sv
module ssc_profile_gen_bench;

   localparam int P    = 4000;
   localparam int Q    = P / 4;
   localparam int A_LO = 50;
   localparam int A_HI = 150;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pd_n = 1'b0;
   logic mod_en = 1'b0;
   logic spread_down = 1'b0;
   logic depth_hi = 1'b0;
   logic signed [9:0] offset;
   logic active;

   always #10 clk = ~clk;

   ssc_profile_gen u_ssc_profile_gen (
      .clk           (clk),
      .rst_n         (rst_n),
      .pd_n          (pd_n),
      .mod_en_i      (mod_en),
      .spread_down_i (spread_down),
      .depth_hi_i    (depth_hi),
      .offset_o      (offset),
      .active_o      (active)
   );

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   task automatic check(bit ok, string req, int act, int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   // Expected offset from the triangle formula of R2, R3 and R4
   function automatic int exp_off(int t, bit dn, bit dp);
      int amp, q, r, f, v;
      amp = dp ? A_HI : A_LO;
      q = t / Q;
      r = t % Q;
      f = (amp * r) / Q;
      case (q)
         0:       v = f;
         1:       v = amp - f;
         2:       v = -f;
         default: v = -amp + f;
      endcase
      return v + (dn ? -amp : 0);
   endfunction

   // Reference timeline built from R4, R7, R8 and R9
   bit m_act = 1'b0;
   int m_t   = 0;
   bit m_dn  = 1'b0;
   bit m_dp  = 1'b0;
   int nt;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_act <= 1'b0; m_t <= 0; m_dn <= 1'b0; m_dp <= 1'b0;
      end else if (!(pd_n && mod_en) || !m_act) begin
         m_act <= pd_n && mod_en;
         m_t   <= 0;
         m_dn  <= spread_down;
         m_dp  <= depth_hi;
      end else begin
         nt = (m_t == P - 1) ? 0 : m_t + 1;
         m_t <= nt;
         if (nt == 0 || nt == 2 * Q) begin
            m_dn <= spread_down;
            m_dp <= depth_hi;
         end
      end
   end

   // Cycle-by-cycle comparison, sampled at the falling edge
   bit mon_on = 1'b0;
   bit p_act  = 1'b0;
   bit p_dn   = 1'b0;
   bit p_dp   = 1'b0;
   int p_off  = 0;

   always @(negedge clk) begin
      if (mon_on) begin
         int e, d;
         e = m_act ? exp_off(m_t, m_dn, m_dp) : 0;
         check(int'(offset) == e, "R4/R8 profile", int'(offset), e);
         check(active == m_act, "R9 active", int'(active), int'(m_act));
         if (p_act && m_act && p_dn == m_dn && p_dp == m_dp) begin
            d = int'(offset) - p_off;
            check(d >= -1 && d <= 1, "R10 step", d, 0);
         end
         p_act = m_act; p_dn = m_dn; p_dp = m_dp; p_off = int'(offset);
      end
   end

   task automatic window(int n, output int mx, output int mn);
      mx = -1000;
      mn = 1000;
      repeat (n) begin
         @(negedge clk);
         if (int'(offset) > mx) mx = int'(offset);
         if (int'(offset) < mn) mn = int'(offset);
      end
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         n_fail++;
         n_tests++;
         $display("FAIL watchdog: got 0 expected 1");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      int mx, mn, seed, cnt_en, cnt_pd;
      seed = $urandom(32'h5eed);

      repeat (4) @(negedge clk);
      check(offset == 0, "R1 offset", int'(offset), 0);
      check(active == 1'b0, "R1 active", int'(active), 0);
      rst_n = 1'b1;
      @(negedge clk);
      mon_on = 1'b1;

      // Center, deep
      spread_down = 1'b0; depth_hi = 1'b1; pd_n = 1'b1; mod_en = 1'b1;
      @(negedge clk);
      check(active == 1'b1, "R9 start", int'(active), 1);
      check(offset == 0, "R7 center midpoint", int'(offset), 0);
      window(P, mx, mn);
      check(mx == 150, "R2 center deep peak", mx, 150);
      check(mn == -150, "R2 center deep trough", mn, -150);

      // Center, shallow
      depth_hi = 1'b0;
      repeat (P) @(negedge clk);
      window(P, mx, mn);
      check(mx == 50, "R2 center shallow peak", mx, 50);
      check(mn == -50, "R2 center shallow trough", mn, -50);

      // Down, deep
      spread_down = 1'b1; depth_hi = 1'b1;
      repeat (P) @(negedge clk);
      window(P, mx, mn);
      check(mx == 0, "R3 down deep top", mx, 0);
      check(mn == -300, "R3 down deep bottom", mn, -300);

      // Down, shallow
      depth_hi = 1'b0;
      repeat (P) @(negedge clk);
      window(P, mx, mn);
      check(mx == 0, "R3 down shallow top", mx, 0);
      check(mn == -100, "R3 down shallow bottom", mn, -100);

      // Depth change in the middle of a ramp is deferred
      while (m_t != Q / 2) @(negedge clk);
      depth_hi = 1'b1;
      window(Q, mx, mn);
      check(mn >= -100, "R8 deferred depth", mn, -100);
      while (m_t != 3 * Q) @(negedge clk);
      check(offset == -300, "R8 applied at midpoint", int'(offset), -300);

      // Modulation disable
      mod_en = 1'b0;
      @(negedge clk);
      check(offset == 0, "R5 disabled offset", int'(offset), 0);
      check(active == 1'b0, "R5 disabled active", int'(active), 0);
      repeat (3) @(negedge clk);
      check(offset == 0, "R5 held off", int'(offset), 0);
      mod_en = 1'b1;
      @(negedge clk);
      check(offset == -150, "R7 down midpoint", int'(offset), -150);

      // Power-down, style changed while idle
      repeat (777) @(negedge clk);
      pd_n = 1'b0;
      spread_down = 1'b0;
      @(negedge clk);
      check(offset == 0, "R6 powerdown offset", int'(offset), 0);
      check(active == 1'b0, "R6 powerdown active", int'(active), 0);
      repeat (5) @(negedge clk);
      pd_n = 1'b1;
      @(negedge clk);
      check(offset == 0, "R7 restart center", int'(offset), 0);
      check(active == 1'b1, "R9 restart active", int'(active), 1);

      // Constrained random selects, disable and power-down pulses
      cnt_en = 0;
      cnt_pd = 0;
      for (int i = 0; i < 40000; i++) begin
         int r;
         @(negedge clk);
         r = int'($urandom % 6000);
         if (r == 0) spread_down = ~spread_down;
         if (r == 1 || r == 2) depth_hi = ~depth_hi;
         if (cnt_en > 0) cnt_en--;
         else if (r == 3) cnt_en = 1 + int'($urandom % 3);
         if (cnt_pd > 0) cnt_pd--;
         else if (r == 4) cnt_pd = 1 + int'($urandom % 4);
         mod_en = (cnt_en == 0);
         pd_n   = (cnt_pd == 0);
      end
      mod_en = 1'b1;
      pd_n   = 1'b1;
      repeat (4) @(negedge clk);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule